// File: doc/BRIEF.md
# Threshold-Based Hot Page Filter

This block sits in front of a die-stacked or on-package DRAM cache and decides which operating-system pages are worth bringing into it. Rather than keeping a tag for every page of memory, it keeps a small fully associative table of pages that were touched lately. Each table slot holds a page number and a saturating hit counter. A page earns a place in the cache only after its counter climbs to a threshold that software sets.

Each access presents one page number. A page that is absent takes a table slot and starts at a count of one. A page that is present has its count raised by one. When the new count is at or above the threshold, the page number goes into a small promotion queue and its table slot is freed. If the queue has no room, the slot keeps the page with its count clamped to the threshold. The promotion is then retried on the next access to that page. The cache fill logic drains the queue through a valid/ready handshake.

Top module: `hot_page_filter`

## Requirements
- R1: After reset the table holds no pages and `prom_valid` is low.
- R2: An access to a page that is not in the table allocates a slot for it with a count of 1. If 1 already meets `thresh`, including a threshold of 0 or 1, the page is promoted on that first access.
- R3: An access to a page already in the table raises its count by one. The access that makes the count reach `thresh` pushes the page into the queue, and `prom_valid` shows it in the cycle after that access.
- R4: A promoted page's slot is invalidated, so a later access to that page starts again from a count of 1.
- R5: A missing page takes the lowest-index free slot. When all slots are in use, it replaces the slot with the smallest count, with ties going to the lowest index.
- R6: Promotions leave the queue in the order they were made, up to `FIFO_DEPTH` of them (4 by default). The head page stays on `prom_page` while `prom_valid` is high and `prom_ready` is low.
- R7: When the queue is full, a page that reaches the threshold is not pushed. Its slot keeps the page with its count held at `thresh`, so that page's next access promotes it once space is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_page | input | PAGE_W | Page number of the access |
| thresh | input | CNT_W | Count at which a page is promoted |
| prom_valid | output | 1 | Queue head holds a promoted page |
| prom_page | output | PAGE_W | Page number at the queue head |
| prom_ready | input | 1 | Consumer takes the head this cycle |

## Verification
Several properties are checked on every clock cycle. No page ever matches more than one valid slot. A promoted slot is empty on the following cycle. The queue is never pushed while it is full, and its level never goes past its depth. The queue head holds still while the consumer stalls. Other behaviour only shows up over whole access sequences, so the bench scenarios cover it. These include the exact access on which a page crosses the threshold, and which slot a full table gives up: lowest index among the smallest counts, checked through later promotion timing. They also include a deferred page being promoted by a single later access, and the order in which the queue drains.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
   typedef enum logic [1:0] {
      UPD_IDLE    = 2'd0,
      UPD_COUNT   = 2'd1,
      UPD_PROMOTE = 2'd2,
      UPD_DEFER   = 2'd3
   } upd_e;
endpackage

// File: rtl/hpf_lookup.sv
module hpf_lookup #(
   parameter int ENTRIES = 16,
   parameter int PAGE_W  = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]             valid_vec,
   input  logic [ENTRIES-1:0][PAGE_W-1:0] tag_vec,
   input  logic [PAGE_W-1:0]              page,
   output logic [ENTRIES-1:0]             hit_vec,
   output logic                           hit,
   output logic [IDX_W-1:0]               hit_idx
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_vec[g] && (tag_vec[g] == page);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/hpf_victim.sv
module hpf_victim #(
   parameter int ENTRIES = 16,
   parameter int CNT_W   = 6,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid_vec,
   input  logic [ENTRIES-1:0][CNT_W-1:0] cnt_vec,
   output logic [IDX_W-1:0]              victim_idx
);
   logic             have_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] min_idx;
   logic [CNT_W-1:0] min_cnt;

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   always_comb begin
      min_idx = '0;
      min_cnt = cnt_vec[0];
      for (int i = 1; i < ENTRIES; i++) begin
         if (cnt_vec[i] < min_cnt) begin
            min_cnt = cnt_vec[i];
            min_idx = IDX_W'(i);
         end
      end
   end

   assign victim_idx = have_free ? free_idx : min_idx;
endmodule

// File: rtl/hpf_promote_fifo.sv
module hpf_promote_fifo #(
   parameter int DEPTH  = 4,
   parameter int PAGE_W = 20,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PAGE_W-1:0] push_page,
   output logic              full,
   output logic              out_valid,
   output logic [PAGE_W-1:0] out_page,
   input  logic              out_ready
);
   logic [DEPTH-1:0][PAGE_W-1:0] store_q;
   logic [PTR_W-1:0]             wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [LVL_W-1:0]             level_q;
   logic                         pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("hpf_promote_fifo: DEPTH must be at least 2");
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr_q + PTR_W'(1);
      assign rd_nxt = rd_ptr_q + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
   end

   assign full      = (level_q == LVL_W'(DEPTH));
   assign out_valid = (level_q != '0);
   assign out_page  = store_q[rd_ptr_q];
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         if (push) begin
            store_q[wr_ptr_q] <= push_page;
            wr_ptr_q          <= wr_nxt;
         end
         if (pop) rd_ptr_q <= rd_nxt;
         if (push && !pop)      level_q <= level_q + LVL_W'(1);
         else if (pop && !push) level_q <= level_q - LVL_W'(1);
      end
   end

   // R7
   no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_W'(DEPTH));
endmodule

// File: rtl/hot_page_filter.sv
module hot_page_filter #(
   parameter int PAGE_W     = 20,
   parameter int ENTRIES    = 16,
   parameter int CNT_W      = 6,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [PAGE_W-1:0] acc_page,
   input  logic [CNT_W-1:0]  thresh,
   output logic              prom_valid,
   output logic [PAGE_W-1:0] prom_page,
   input  logic              prom_ready
);
   import hpf_pkg::*;

   localparam int              IDX_W   = $clog2(ENTRIES);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("hot_page_filter: ENTRIES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("hot_page_filter: CNT_W must be at least 2");
   end

   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][PAGE_W-1:0] tag_q;
   logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;

   logic [ENTRIES-1:0] hit_vec;
   logic               hit;
   logic [IDX_W-1:0]   hit_idx, vic_idx, slot;
   logic [CNT_W-1:0]   base_cnt, next_cnt;
   logic               reach, fifo_full;
   upd_e               act;

   hpf_lookup #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) lookup_i (
      .valid_vec(valid_q), .tag_vec(tag_q), .page(acc_page),
      .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx));

   hpf_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) victim_i (
      .valid_vec(valid_q), .cnt_vec(cnt_q), .victim_idx(vic_idx));

   always_comb begin
      base_cnt = cnt_q[hit_idx];
      if (!hit)                    next_cnt = CNT_W'(1);
      else if (base_cnt == CNT_MAX) next_cnt = CNT_MAX;
      else                         next_cnt = base_cnt + CNT_W'(1);
      reach = (next_cnt >= thresh);
      slot  = hit ? hit_idx : vic_idx;
      if (!acc_valid)      act = UPD_IDLE;
      else if (!reach)     act = UPD_COUNT;
      else if (!fifo_full) act = UPD_PROMOTE;
      else                 act = UPD_DEFER;
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            cnt_q[g]   <= '0;
         end else if (acc_valid && (slot == IDX_W'(g))) begin
            unique case (act)
               UPD_PROMOTE: valid_q[g] <= 1'b0;
               UPD_DEFER: begin
                  valid_q[g] <= 1'b1;
                  tag_q[g]   <= acc_page;
                  cnt_q[g]   <= thresh;
               end
               UPD_COUNT: begin
                  valid_q[g] <= 1'b1;
                  tag_q[g]   <= acc_page;
                  cnt_q[g]   <= next_cnt;
               end
               default: ;
            endcase
         end
      end
   end

   hpf_promote_fifo #(.DEPTH(FIFO_DEPTH), .PAGE_W(PAGE_W)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(act == UPD_PROMOTE), .push_page(acc_page), .full(fifo_full),
      .out_valid(prom_valid), .out_page(prom_page), .out_ready(prom_ready));

   // R3
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_vec) <= 1);

   // R4
   prom_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == UPD_PROMOTE) |=> !valid_q[$past(slot)]);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prom_valid && !prom_ready) |=> (prom_valid && $stable(prom_page)));

   // R1
   reset_empty_chk: assert property (@(posedge clk)
      !rst_n |=> (!prom_valid && (valid_q == '0)));
endmodule

// File: tb/hot_page_filter_tb.sv
`timescale 1ns/1ps
module hot_page_filter_tb_top;
   localparam int PAGE_W = 20;
   localparam int CNT_W  = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic [PAGE_W-1:0] acc_page = '0;
   logic [CNT_W-1:0]  thresh = CNT_W'(3);
   logic              prom_valid;
   logic [PAGE_W-1:0] prom_page;
   logic              prom_ready = 1'b1;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [PAGE_W-1:0] exp_q[$];

   always #10 clk = ~clk;

   hot_page_filter dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
      .thresh(thresh), .prom_valid(prom_valid), .prom_page(prom_page),
      .prom_ready(prom_ready));

   task automatic chk(input string req, input longint got, input longint expv);
      checks++;
      if (got != expv) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", req, got, expv);
      end
   endtask

   // scoreboard monitor: compares each accepted promotion with the queue
   always begin
      @(negedge clk);
      #1;
      if (rst_n && prom_valid && prom_ready) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R3: got promotion of page %0d expected none", prom_page);
         end else begin
            logic [PAGE_W-1:0] e;
            e = exp_q.pop_front();
            if (prom_page != e) begin
               failures++;
               $display("FAIL R6: got page %0d expected %0d", prom_page, e);
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic access(input int page, input bit expect_prom);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_page  = PAGE_W'(page);
      if (expect_prom) exp_q.push_back(PAGE_W'(page));
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      acc_valid = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic drained(input string req);
      idle(8);
      chk(req, exp_q.size(), 0);
      chk(req, prom_valid, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1", prom_valid, 0);

      // R2/R3: threshold 3, promoted on third access
      thresh = CNT_W'(3);
      access(10, 0);
      access(10, 0);
      access(10, 1);
      #1;
      chk("R3", prom_valid, 1);
      chk("R3", prom_page, 10);
      drained("R3");

      // R4: entry freed, counting starts over
      access(10, 0);
      access(10, 0);
      drained("R4");
      access(10, 1);
      drained("R4");

      // R2: threshold 1 and 0 promote on first access
      thresh = CNT_W'(1);
      access(5, 1);
      drained("R2");
      thresh = CNT_W'(0);
      access(6, 1);
      drained("R2");

      // R1: reset empties table
      thresh = CNT_W'(3);
      access(20, 0);
      access(20, 0);
      do_reset();
      access(20, 0);
      drained("R1");
      access(20, 0);
      access(20, 1);
      drained("R1");

      // R5: replacement by smallest count, lowest index
      do_reset();
      thresh = CNT_W'(10);
      for (int i = 0; i < 16; i++) access(100 + i, 0);
      for (int i = 0; i < 16; i++) if (i != 3 && i != 7) access(100 + i, 0);
      access(200, 0);               // replaces page 103 (slot 3)
      for (int i = 0; i < 8; i++) access(107, 0);
      access(107, 1);               // 107 kept: count 10 on ninth access
      drained("R5");
      for (int i = 0; i < 9; i++) access(103, 0);
      drained("R5");                // 103 restarted from 1
      access(103, 1);
      drained("R5");

      // R6/R7: full queue, stall and deferral
      do_reset();
      thresh = CNT_W'(2);
      prom_ready = 1'b0;
      for (int p = 1; p <= 4; p++) begin
         access(p, 0);
         access(p, 1);
      end
      #1;
      chk("R6", prom_valid, 1);
      chk("R6", prom_page, 1);
      access(5, 0);
      access(5, 0);                 // deferred, queue full
      idle(3);
      #1;
      chk("R6", prom_page, 1);
      chk("R7", exp_q.size(), 4);
      @(negedge clk);
      prom_ready = 1'b1;
      drained("R7");
      access(5, 1);                 // held at threshold, one access promotes
      drained("R7");

      finish_run();
   end
endmodule